// File: doc/BRIEF.md
# Range-Matched LRU Translation Cache

This block is a small, fully associative cache of address translations. Each slot holds a virtual base, a physical base, a page size given as a base-two logarithm, and a global flag. Every slot can therefore cover a page of a different size. A lookup compares the address against the range of every slot at once. The response arrives one cycle later and carries a hit flag and the translated physical address.

Recency is tracked as a rank per slot, where rank 0 is the most recently used. Inserts fill an empty slot when one exists and otherwise replace the least recently used slot. A lookup can optionally promote the slot that hit. Three maintenance commands release slots back to the free pool: a full flush, a flush that spares global slots, and a demap of the single slot covering a given address. None of the three reorders the slots that remain.

Top module: `tlb_lru_xlate`

## Requirements
- R1: An insert writes into an empty slot whenever one exists. Only when every slot is valid does it replace the valid slot of highest rank, the least recently used.
- R2: A slot that has just been written becomes the most recently used.
- R3: A slot matches address `va` when `vbase <= va < vbase + 2**size_lg`. A lookup that matches no valid slot reports a miss.
- R4: On a hit, `pa_o` equals `pbase | (va & (2**size_lg - 1))`. On a miss, `pa_o` is zero.
- R5: When `lkp_promote_i` is 1, a hit moves that slot to most recently used. When it is 0, the recency order is left unchanged.
- R6: Command code 2'b01 invalidates every slot.
- R7: Command code 2'b10 invalidates every slot whose global flag is 0. Global slots keep their relative recency order.
- R8: Command code 2'b11 invalidates only the single slot that a lookup of `cmd_va_i` would select. The order of the other slots is unchanged.
- R9: When several valid slots match an address, the most recently used one supplies the translation.
- R10: `rsp_valid_o`, `hit_o` and `pa_o` are registered. They reflect a lookup presented in the previous cycle, and `rsp_valid_o` is 0 in a cycle after no lookup.
- R11: A nonzero command in the same cycle as an insert wins, and the insert is dropped. Code 2'b00 means no command.
- R12: After reset, no slot is valid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ins_i | input | 1 | Insert request |
| ins_vbase_i | input | VA_W | Virtual base of the new slot |
| ins_pbase_i | input | PA_W | Physical base of the new slot |
| ins_size_lg_i | input | LG_W | Page size as a base-two logarithm |
| ins_global_i | input | 1 | Global flag of the new slot |
| lkp_i | input | 1 | Lookup request |
| lkp_va_i | input | VA_W | Lookup address |
| lkp_promote_i | input | 1 | Promote the slot that hits to most recently used |
| cmd_i | input | 2 | Maintenance command: 00 none, 01 flush all, 10 flush non-global, 11 demap |
| cmd_va_i | input | VA_W | Address used by the demap command |
| rsp_valid_o | output | 1 | Registered response valid |
| hit_o | output | 1 | Registered hit flag |
| pa_o | output | PA_W | Registered physical address |

## Verification
The assertions assume the following about inputs:
- Reset is applied before any request.
- Requests are sampled at clock edges only.
- Base addresses are aligned to their page size.
- A page range never wraps past the top of the address space.

The stimulus respects these assumptions in the following ways:
- It uses only aligned bases and sizes well below the address width.
- It drives every request on the falling edge.
- It holds all requests low through reset.
- Overlapping entries are created deliberately, so that the rule that the most recently used slot wins is exercised inside these limits.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef enum logic [1:0] {
    CMD_NONE        = 2'b00,
    CMD_FLUSH_ALL   = 2'b01,
    CMD_FLUSH_LOCAL = 2'b10,
    CMD_DEMAP       = 2'b11
  } tlb_cmd_e;
endpackage

// File: rtl/tlb_range_match.sv
`timescale 1ns/1ps
module tlb_range_match #(
  parameter int VA_W = 32,
  parameter int LG_W = 6
) (
  input  logic            valid_i,
  input  logic [VA_W-1:0] vbase_i,
  input  logic [LG_W-1:0] size_lg_i,
  input  logic [VA_W-1:0] va_i,
  output logic            hit_o
);
  logic [VA_W:0] limit;
  // One extra bit so that a page ending at the top of the space cannot wrap.
  assign limit = {1'b0, vbase_i} + ((VA_W+1)'(1) << size_lg_i);
  assign hit_o = valid_i && (va_i >= vbase_i) && ({1'b0, va_i} < limit);
endmodule

// File: rtl/tlb_pick_mru.sv
`timescale 1ns/1ps
module tlb_pick_mru #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]            match_i,
  input  logic [N-1:0][IDX_W-1:0] age_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [IDX_W-1:0] best_age;
  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    best_age = '1;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && (!any_o || age_i[i] < best_age)) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        best_age = age_i[i];
      end
    end
  end
endmodule

// File: rtl/tlb_recency.sv
`timescale 1ns/1ps
module tlb_recency #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    touch_i,
  input  logic [IDX_W-1:0]        touch_idx_i,
  output logic [N-1:0][IDX_W-1:0] age_o
);
  logic [N-1:0][IDX_W-1:0] age_q, age_d;

  // Ranks stay a permutation of 0..N-1: younger than the touched slot age by one.
  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i)             age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx_i])   age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/tlb_lru_xlate.sv
`timescale 1ns/1ps
module tlb_lru_xlate #(
  parameter int ENTRIES = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int LG_W    = $clog2(VA_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ins_i,
  input  logic [VA_W-1:0] ins_vbase_i,
  input  logic [PA_W-1:0] ins_pbase_i,
  input  logic [LG_W-1:0] ins_size_lg_i,
  input  logic            ins_global_i,
  input  logic            lkp_i,
  input  logic [VA_W-1:0] lkp_va_i,
  input  logic            lkp_promote_i,
  input  logic [1:0]      cmd_i,
  input  logic [VA_W-1:0] cmd_va_i,
  output logic            rsp_valid_o,
  output logic            hit_o,
  output logic [PA_W-1:0] pa_o
);
  import tlb_pkg::*;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][VA_W-1:0] vbase_q;
  logic [ENTRIES-1:0][PA_W-1:0] pbase_q;
  logic [ENTRIES-1:0][LG_W-1:0] lg_q;
  logic [ENTRIES-1:0]           glob_q;
  logic [ENTRIES-1:0]           valid_q, valid_d;
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;

  logic [ENTRIES-1:0] lk_match, dm_match;
  logic               lk_hit, dm_hit;
  logic [IDX_W-1:0]   lk_idx, dm_idx;

  tlb_cmd_e cmd;
  assign cmd = tlb_cmd_e'(cmd_i);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    tlb_range_match #(.VA_W(VA_W), .LG_W(LG_W)) u_lk (
      .valid_i(valid_q[g]), .vbase_i(vbase_q[g]), .size_lg_i(lg_q[g]),
      .va_i(lkp_va_i), .hit_o(lk_match[g]));
    tlb_range_match #(.VA_W(VA_W), .LG_W(LG_W)) u_dm (
      .valid_i(valid_q[g]), .vbase_i(vbase_q[g]), .size_lg_i(lg_q[g]),
      .va_i(cmd_va_i), .hit_o(dm_match[g]));
  end

  tlb_pick_mru #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_lk (
    .match_i(lk_match), .age_i(age_q), .any_o(lk_hit), .idx_o(lk_idx));
  tlb_pick_mru #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_dm (
    .match_i(dm_match), .age_i(age_q), .any_o(dm_hit), .idx_o(dm_idx));

  // Victim: lowest empty slot, else the slot holding the oldest rank.
  logic             full;
  logic [IDX_W-1:0] free_idx, lru_idx, ins_idx;
  always_comb begin
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
      if (age_q[i] == IDX_W'(ENTRIES-1)) lru_idx = IDX_W'(i);
    end
  end
  assign full    = &valid_q;
  assign ins_idx = full ? lru_idx : free_idx;

  logic do_ins, do_prom, touch;
  logic [IDX_W-1:0] touch_idx;
  assign do_ins    = ins_i && (cmd == CMD_NONE);
  assign do_prom   = lkp_i && lkp_promote_i && lk_hit && (cmd == CMD_NONE) && !ins_i;
  assign touch     = do_ins || do_prom;
  assign touch_idx = do_ins ? ins_idx : lk_idx;

  tlb_recency #(.N(ENTRIES), .IDX_W(IDX_W)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(touch_idx), .age_o(age_q));

  always_comb begin
    valid_d = valid_q;
    unique case (cmd)
      CMD_FLUSH_ALL:   valid_d = '0;
      CMD_FLUSH_LOCAL: valid_d = valid_q & glob_q;
      CMD_DEMAP:       if (dm_hit) valid_d[dm_idx] = 1'b0;
      default:         if (do_ins) valid_d[ins_idx] = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      vbase_q <= '0;
      pbase_q <= '0;
      lg_q    <= '0;
      glob_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (do_ins) begin
        vbase_q[ins_idx] <= ins_vbase_i;
        pbase_q[ins_idx] <= ins_pbase_i;
        lg_q[ins_idx]    <= ins_size_lg_i;
        glob_q[ins_idx]  <= ins_global_i;
      end
    end
  end

  logic [VA_W-1:0] off_mask;
  logic [PA_W-1:0] pa_d;
  assign off_mask = (VA_W'(1) << lg_q[lk_idx]) - VA_W'(1);
  assign pa_d     = pbase_q[lk_idx] | PA_W'(lkp_va_i & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      pa_o        <= '0;
    end else begin
      rsp_valid_o <= lkp_i;
      hit_o       <= lkp_i && lk_hit;
      pa_o        <= (lkp_i && lk_hit) ? pa_d : '0;
    end
  end
endmodule

// File: rtl/tlb_lru_checker.sv
`timescale 1ns/1ps
module tlb_lru_checker #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ins_i,
  input logic                    lkp_i,
  input logic [1:0]              cmd_i,
  input logic                    rsp_valid_o,
  input logic                    hit_o,
  input logic [N-1:0]            valid_q,
  input logic [N-1:0][IDX_W-1:0] age_q
);
  logic [N-1:0] rank0;
  for (genvar g = 0; g < N; g++) begin : g_r0
    assign rank0[g] = (age_q[g] == '0);
  end

  p_rsp_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(lkp_i));

  p_flush_all_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b01) ##1 lkp_i |=> !hit_o);

  p_fill_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && cmd_i == 2'b00 && !(&valid_q)) |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1);

  p_full_stays_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && cmd_i == 2'b00 && (&valid_q)) |=> (&valid_q));

  p_single_mru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(rank0));

  p_cmd_beats_ins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && cmd_i != 2'b00) |=> $countones(valid_q) <= $past($countones(valid_q)));
endmodule

bind tlb_lru_xlate tlb_lru_checker #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_i(ins_i), .lkp_i(lkp_i), .cmd_i(cmd_i),
  .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .valid_q(valid_q), .age_q(age_q));

// File: tb/tlb_lru_xlate_test.sv
`timescale 1ns/1ps
module tlb_lru_xlate_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ins = 0, ins_g = 0, lkp = 0, prom = 0;
  logic [31:0] ins_vb = 0, ins_pb = 0, lkp_va = 0, cmd_va = 0;
  logic [5:0]  ins_lg = 0;
  logic [1:0]  cmd = 0;
  logic        rsp_v, hit;
  logic [31:0] pa;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_lru_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .ins_i(ins), .ins_vbase_i(ins_vb),
    .ins_pbase_i(ins_pb), .ins_size_lg_i(ins_lg), .ins_global_i(ins_g),
    .lkp_i(lkp), .lkp_va_i(lkp_va), .lkp_promote_i(prom), .cmd_i(cmd),
    .cmd_va_i(cmd_va), .rsp_valid_o(rsp_v), .hit_o(hit), .pa_o(pa));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] vb, pb, input logic [5:0] lg, input bit g,
                     input logic [1:0] c = 2'b00);
    @(negedge clk);
    ins = 1; ins_vb = vb; ins_pb = pb; ins_lg = lg; ins_g = g; cmd = c;
    @(negedge clk);
    ins = 0; cmd = 0;
  endtask

  task automatic maint(input logic [1:0] c, input logic [31:0] va = 0);
    @(negedge clk);
    cmd = c; cmd_va = va;
    @(negedge clk);
    cmd = 0;
  endtask

  task automatic look(input logic [31:0] va, input bit p, input bit eh,
                      input logic [31:0] ep, input string tag);
    @(negedge clk);
    lkp = 1; lkp_va = va; prom = p;
    @(negedge clk);
    lkp = 0; prom = 0;
    check(rsp_v == 1'b1, {tag, " R10 rsp_valid"}, 32'(rsp_v), 32'd1);
    check(hit == eh, {tag, " hit"}, 32'(hit), 32'(eh));
    check(pa == ep, {tag, " pa"}, pa, ep);
  endtask

  // {va, expected hit, expected pa}; R3 ranges and R4 offsets
  localparam logic [64:0] TBL [10] = '{
    {32'h0000_1000, 1'b1, 32'h8000_0000},
    {32'h0000_1FFF, 1'b1, 32'h8000_0FFF},
    {32'h0000_2000, 1'b0, 32'h0000_0000},
    {32'h0000_0FFF, 1'b0, 32'h0000_0000},
    {32'h0020_0000, 1'b1, 32'h4000_0000},
    {32'h003F_FFFF, 1'b1, 32'h401F_FFFF},
    {32'h0040_0000, 1'b0, 32'h0000_0000},
    {32'h0000_3ABC, 1'b1, 32'h9000_0ABC},
    {32'h1000_1234, 1'b1, 32'h2345_1234},
    {32'h1001_0000, 1'b0, 32'h0000_0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_v == 0 && hit == 0 && pa == 0, "R12 outputs in reset", pa, 0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_v == 0, "R10 idle rsp_valid", 32'(rsp_v), 0);
    look(32'h0000_1000, 0, 0, 0, "R12 empty after reset");

    put(32'h0000_1000, 32'h8000_0000, 12, 0);   // A
    put(32'h0020_0000, 32'h4000_0000, 21, 1);   // B
    put(32'h0000_3000, 32'h9000_0000, 12, 0);   // C
    put(32'h1000_0000, 32'h2345_0000, 16, 1);   // D
    for (int i = 0; i < 10; i++)
      look(TBL[i][64:33], 0, TBL[i][32], TBL[i][31:0], $sformatf("R3 R4 vec%0d", i));

    // order D C B A; promote A, then insert E evicts B
    look(32'h0000_1000, 1, 1, 32'h8000_0000, "R5 promote A");
    put(32'h0000_5000, 32'hA000_0000, 12, 1);   // E
    look(32'h0020_0000, 0, 0, 0, "R1 R5 LRU B evicted");
    look(32'h0000_1000, 0, 1, 32'h8000_0000, "R5 promoted A kept");
    look(32'h0000_5010, 0, 1, 32'hA000_0010, "R2 E present");
    // order E A D C; non-promoting hit on C leaves C oldest
    look(32'h0000_3000, 0, 1, 32'h9000_0000, "R5 plain hit C");
    put(32'h0000_6000, 32'hB000_0000, 12, 0);   // F
    look(32'h0000_3000, 0, 0, 0, "R5 C evicted despite hit");
    // order F E A D
    put(32'h0000_7000, 32'hD000_0000, 12, 1);   // G evicts D
    look(32'h1000_0000, 0, 0, 0, "R1 D evicted");
    // order G F E A; H overlaps G, evicts A
    put(32'h0000_7000, 32'hC000_0000, 12, 0);   // H
    look(32'h0000_7010, 0, 1, 32'hC000_0010, "R9 MRU overlap wins");
    look(32'h0000_6000, 0, 1, 32'hB000_0000, "R2 F survived");

    maint(2'b11, 32'h0000_7010);                 // demap frees H only
    look(32'h0000_7010, 0, 1, 32'hD000_0010, "R8 demap one slot");
    put(32'h0000_8000, 32'hE000_0000, 12, 0);   // I into freed slot
    look(32'h0000_5000, 0, 1, 32'hA000_0000, "R1 R8 free slot used first");

    // order I G F E; globals G, E
    maint(2'b10);
    look(32'h0000_8000, 0, 0, 0, "R7 non-global I freed");
    look(32'h0000_6000, 0, 0, 0, "R7 non-global F freed");
    look(32'h0000_7000, 0, 1, 32'hD000_0000, "R7 global G kept");
    put(32'h0000_9000, 32'hF000_0000, 12, 0);   // J
    put(32'h0000_A000, 32'hF100_0000, 12, 0);   // K
    put(32'h0000_B000, 32'hF200_0000, 12, 0);   // L evicts E (older global)
    look(32'h0000_5000, 0, 0, 0, "R7 global order kept E oldest");
    look(32'h0000_7000, 0, 1, 32'hD000_0000, "R7 G still present");

    put(32'h0000_C000, 32'hF300_0000, 12, 0, 2'b01);  // insert with flush-all
    look(32'h0000_C000, 0, 0, 0, "R11 insert dropped");
    look(32'h0000_7000, 0, 0, 0, "R6 flush all");
    look(32'h0000_9000, 0, 0, 0, "R6 flush all J");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule